// File: doc/BRIEF.md
# Bus-Master Clock and PLL Multiplier Control Unit

This unit holds two small control registers for a microcontroller clock system. The first register picks the rate at which the bus master runs. It can run at full rate, or at a medium-speed rate that is the input clock divided by 2, 4, 8, 16 or 32. The unit turns that choice into a one-cycle clock-enable pulse, so the bus master logic keeps using the main clock and only advances when the enable is high.

The second register holds the PLL multiplication factor requested by software. That value is kept apart from the factor actually driven to the PLL. A mode bit in the first register decides when a requested factor is applied. With the mode bit clear, the factor is applied only when the chip returns from a low-power state, which is signalled by a one-cycle strobe. With the mode bit set, the factor is applied at the moment software writes it. A hardware standby input clears the power register and the applied factor. The rate selection and the mode bit survive standby.

Software reaches both registers through a single-address write port and a combinational read port. Address 0 is the clock-select register and address 1 is the power register.

Top module: `clkctl_unit`

## Requirements
- R1: After reset both registers read 0x00, `pll_mult` is 0, and `bm_clk_en` is high on every cycle (full rate).
- R2: Clock-select field code k in bits 2:0 of address 0, for k = 1..5, makes `bm_clk_en` pulse high for exactly one cycle every 2^k cycles. Code 0 holds it high on every cycle.
- R3: A write of code 6 or 7 into the clock-select field leaves the previous code and divide ratio in force. The mode bit (bit 3) in the same write is still taken.
- R4: A new divide code takes effect only at the end of the running period. The pulse spacing seen after a change is the old period once, then the new period, with no shorter interval.
- R5: With the mode bit (address 0, bit 3) at 1, a write of the factor into bits 1:0 of address 1 appears on `pll_mult` from the cycle after the write.
- R6: With the mode bit at 0, a factor write leaves `pll_mult` unchanged. A one-cycle `lp_exit` strobe then copies the stored factor to `pll_mult` from the next cycle.
- R7: A cycle with `hw_stby` high clears address 1 to 0x00 and `pll_mult` to 0. Address 0 keeps its contents.
- R8: Reading address 1 returns the stored factor, not the applied one. Bit 2 reads 0 and bits 7:3 read as written. Bits 7:4 of address 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_stby | input | 1 | Hardware standby; clears the power register and the applied factor |
| lp_exit | input | 1 | One-cycle strobe marking return from a low-power state |
| addr | input | 1 | Register select: 0 clock-select, 1 power |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register (combinational) |
| bm_clk_en | output | 1 | Bus-master clock enable |
| pll_mult | output | 2 | Multiplication factor applied to the PLL |

## Verification
A corrupted applied factor shows on `pll_mult` in the cycle after the fault. It stays wrong until the next standby, low-power exit or immediate-mode write, so the bench compares the factor right after every such event. A wrong divide code or counter shows as a pulse spacing that differs from 2^k within at most 32 cycles, and the bench measures the spacing after each code change. A runt interval at a switch shows only at the single transition period, so that period is checked by itself.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
   localparam int unsigned CC_DATA_W   = 8;
   localparam int unsigned CC_SEL_W    = 3;
   localparam int unsigned CC_MULT_W   = 2;
   localparam int unsigned CC_MAXLOG2  = 5;
   localparam logic        CC_ADR_SEL  = 1'b0;
   localparam logic        CC_ADR_PWR  = 1'b1;

   typedef enum logic [1:0] {
      APPLY_NONE  = 2'd0,
      APPLY_WRITE = 2'd1,
      APPLY_EXIT  = 2'd2,
      APPLY_CLEAR = 2'd3
   } apply_src_e;
endpackage

// File: rtl/clkctl_regs.sv
module clkctl_regs
   import clkctl_pkg::*;
#(
   parameter int unsigned DATA_W  = CC_DATA_W,
   parameter int unsigned SEL_W   = CC_SEL_W,
   parameter int unsigned MULT_W  = CC_MULT_W,
   parameter int unsigned MAXLOG2 = CC_MAXLOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_stby,
   input  logic              addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [SEL_W-1:0]  sel_code,
   output logic              upd_now,
   output logic [MULT_W-1:0] mult_req,
   output logic              mult_wr,
   output logic [MULT_W-1:0] mult_wdata
);
   localparam int unsigned MODE_BIT = SEL_W;
   localparam int unsigned GAP_BIT  = MULT_W;
   localparam logic [DATA_W-1:0] PWR_KEEP = ~(DATA_W'(1) << GAP_BIT);

   logic [DATA_W-1:0] pwr_q;
   logic [SEL_W-1:0]  sel_q;
   logic              mode_q;
   logic              wr_sel, wr_pwr, sel_legal;

   if (MODE_BIT >= DATA_W) begin : g_chk_mode
      $error("clkctl_regs: mode bit does not fit the data width");
   end
   if (GAP_BIT >= DATA_W) begin : g_chk_gap
      $error("clkctl_regs: factor field does not fit the data width");
   end
   if ((1 << SEL_W) <= MAXLOG2) begin : g_chk_sel
      $error("clkctl_regs: select field too narrow for the divider range");
   end

   assign wr_sel    = wr_en && (addr == CC_ADR_SEL);
   assign wr_pwr    = wr_en && (addr == CC_ADR_PWR);
   assign sel_legal = (wr_data[SEL_W-1:0] <= SEL_W'(MAXLOG2));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q  <= '0;
         mode_q <= 1'b0;
      end else if (wr_sel) begin
         mode_q <= wr_data[MODE_BIT];
         if (sel_legal) sel_q <= wr_data[SEL_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || hw_stby) pwr_q <= '0;
      else if (wr_pwr)       pwr_q <= wr_data & PWR_KEEP;
   end

   always_comb begin
      rd_data = '0;
      if (addr == CC_ADR_SEL) begin
         rd_data[SEL_W-1:0] = sel_q;
         rd_data[MODE_BIT]  = mode_q;
      end else begin
         rd_data = pwr_q;
      end
   end

   assign sel_code   = sel_q;
   assign upd_now    = mode_q;
   assign mult_req   = pwr_q[MULT_W-1:0];
   assign mult_wr    = wr_pwr && !hw_stby;
   assign mult_wdata = wr_data[MULT_W-1:0];

   AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      sel_q <= SEL_W'(MAXLOG2)); // R3
   AST_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_q[GAP_BIT] == 1'b0); // R8
   AST_STBY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      hw_stby |=> (pwr_q == '0)); // R7
   AST_SEL_KEEP_STBY: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_stby && !wr_sel) |=> $stable(sel_q) && $stable(mode_q)); // R7
endmodule

// File: rtl/clkctl_rate_gen.sv
module clkctl_rate_gen #(
   parameter int unsigned SEL_W   = 3,
   parameter int unsigned MAXLOG2 = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel_code,
   output logic             clk_en
);
   localparam int unsigned CNT_W = (MAXLOG2 < 1) ? 1 : MAXLOG2;
   localparam int unsigned NCODE = 1 << SEL_W;

   logic [CNT_W-1:0] cnt_q;
   logic [SEL_W-1:0] cur_q;
   logic [NCODE-1:0] hit;

   for (genvar k = 0; k < NCODE; k++) begin : g_hit
      if (k == 0) begin : g_full
         assign hit[k] = 1'b1;
      end else if (k <= MAXLOG2) begin : g_div
         assign hit[k] = &cnt_q[k-1:0];
      end else begin : g_rsvd
         assign hit[k] = 1'b0;
      end
   end

   assign clk_en = hit[cur_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         cur_q <= '0;
      end else if (clk_en) begin
         cnt_q <= '0;
         cur_q <= sel_code;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_SWITCH_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> $stable(cur_q)); // R4
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && cur_q != '0 && sel_code != '0) |=> !clk_en); // R2
   AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q == '0) |-> clk_en); // R2
endmodule

// File: rtl/clkctl_mult_hold.sv
module clkctl_mult_hold
   import clkctl_pkg::*;
#(
   parameter int unsigned MULT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_stby,
   input  logic              lp_exit,
   input  logic              upd_now,
   input  logic              mult_wr,
   input  logic [MULT_W-1:0] mult_wdata,
   input  logic [MULT_W-1:0] mult_req,
   output logic [MULT_W-1:0] mult_act
);
   apply_src_e        src;
   logic [MULT_W-1:0] act_q;

   always_comb begin
      if (hw_stby)                  src = APPLY_CLEAR;
      else if (upd_now && mult_wr)  src = APPLY_WRITE;
      else if (lp_exit)             src = APPLY_EXIT;
      else                          src = APPLY_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= '0;
      end else begin
         unique case (src)
            APPLY_CLEAR: act_q <= '0;
            APPLY_WRITE: act_q <= mult_wdata;
            APPLY_EXIT:  act_q <= mult_req;
            default:     act_q <= act_q;
         endcase
      end
   end

   assign mult_act = act_q;

   AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_now && !lp_exit && !hw_stby) |=> $stable(act_q)); // R6
   AST_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_now && mult_wr && !hw_stby) |=> (act_q == $past(mult_wdata))); // R5
   AST_EXIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_exit && !mult_wr && !hw_stby) |=> (act_q == $past(mult_req))); // R6
   AST_STBY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      hw_stby |=> (act_q == '0)); // R7
endmodule

// File: rtl/clkctl_unit.sv
module clkctl_unit
   import clkctl_pkg::*;
#(
   parameter int unsigned DATA_W  = CC_DATA_W,
   parameter int unsigned SEL_W   = CC_SEL_W,
   parameter int unsigned MULT_W  = CC_MULT_W,
   parameter int unsigned MAXLOG2 = CC_MAXLOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_stby,
   input  logic              lp_exit,
   input  logic              addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              bm_clk_en,
   output logic [MULT_W-1:0] pll_mult
);
   logic [SEL_W-1:0]  sel_code;
   logic              upd_now;
   logic [MULT_W-1:0] mult_req;
   logic              mult_wr;
   logic [MULT_W-1:0] mult_wdata;

   clkctl_regs #(
      .DATA_W(DATA_W), .SEL_W(SEL_W), .MULT_W(MULT_W), .MAXLOG2(MAXLOG2)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby),
      .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .sel_code(sel_code), .upd_now(upd_now), .mult_req(mult_req),
      .mult_wr(mult_wr), .mult_wdata(mult_wdata)
   );

   clkctl_rate_gen #(
      .SEL_W(SEL_W), .MAXLOG2(MAXLOG2)
   ) u_rate (
      .clk(clk), .rst_n(rst_n), .sel_code(sel_code), .clk_en(bm_clk_en)
   );

   clkctl_mult_hold #(
      .MULT_W(MULT_W)
   ) u_mult (
      .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .lp_exit(lp_exit),
      .upd_now(upd_now), .mult_wr(mult_wr), .mult_wdata(mult_wdata),
      .mult_req(mult_req), .mult_act(pll_mult)
   );
endmodule

// File: tb/clkctl_unit_bench.sv
module clkctl_unit_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hw_stby = 1'b0;
   logic       lp_exit = 1'b0;
   logic       addr = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       bm_clk_en;
   logic [1:0] pll_mult;

   int n_cmp = 0;
   int n_bad = 0;

   typedef struct { string req; int exp; } exp_t;
   exp_t sb_q[$];

   always #2.5 clk = ~clk;

   clkctl_unit u_clkctl_unit (
      .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .lp_exit(lp_exit),
      .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .bm_clk_en(bm_clk_en), .pll_mult(pll_mult)
   );

   task automatic push_exp(input string req, input int exp);
      exp_t e;
      e.req = req; e.exp = exp;
      sb_q.push_back(e);
   endtask

   task automatic observe(input int act);
      exp_t e;
      e = sb_q.pop_front();
      n_cmp++;
      if (act != e.exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", e.req, act, e.exp);
      end
   endtask

   task automatic reg_write(input logic a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_read(input logic a, output int v);
      @(negedge clk);
      addr = a;
      #1 v = int'(rd_data);
   endtask

   task automatic pulse(ref logic s);
      @(negedge clk);
      s = 1'b1;
      @(negedge clk);
      s = 1'b0;
   endtask

   task automatic wait_en();
      do @(negedge clk); while (!bm_clk_en);
   endtask

   task automatic next_gap(output int n);
      n = 0;
      do begin @(negedge clk); n++; end while (!bm_clk_en);
   endtask

   task automatic check_reg(input string req, input logic a, input int exp);
      int v;
      push_exp(req, exp);
      reg_read(a, v);
      observe(v);
   endtask

   task automatic check_mult(input string req, input int exp);
      push_exp(req, exp);
      @(negedge clk);
      observe(int'(pll_mult));
   endtask

   task automatic check_period(input string req, input int exp);
      int g;
      wait_en();
      next_gap(g);
      push_exp(req, exp);
      next_gap(g);
      observe(g);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      int g;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check_reg("R1 sel reg", 1'b0, 0);
      check_reg("R1 pwr reg", 1'b1, 0);
      check_mult("R1 pll_mult", 0);
      check_period("R1 full rate", 1);

      // R8 readback shape, R6 deferred apply
      reg_write(1'b1, 8'hFF);
      check_reg("R8 gap bit zero", 1'b1, 8'hFB);
      check_mult("R6 deferred hold", 0);
      pulse(lp_exit);
      check_mult("R6 exit copy", 3);
      reg_write(1'b1, 8'h01);
      check_reg("R8 stored not applied", 1'b1, 8'h01);
      check_mult("R6 hold after write", 3);
      pulse(lp_exit);
      check_mult("R6 second exit copy", 1);

      // R8 upper bits of select reg read zero; R5 immediate
      reg_write(1'b0, 8'hF8);
      check_reg("R8 sel upper zero", 1'b0, 8'h08);
      reg_write(1'b1, 8'h02);
      check_mult("R5 immediate 2", 2);
      reg_write(1'b1, 8'h03);
      check_mult("R5 immediate 3", 3);

      // R7 hardware standby
      reg_write(1'b1, 8'hF9);
      pulse(hw_stby);
      check_reg("R7 pwr cleared", 1'b1, 0);
      check_mult("R7 mult cleared", 0);
      check_reg("R7 sel kept", 1'b0, 8'h08);

      // R2 each divide code
      for (int k = 1; k <= 5; k++) begin
         reg_write(1'b0, 8'(k));
         check_period($sformatf("R2 code %0d", k), 1 << k);
      end
      reg_write(1'b0, 8'h00);
      check_period("R2 code 0", 1);

      // R3 reserved codes
      reg_write(1'b0, 8'h03);
      reg_write(1'b0, 8'h0E);
      check_reg("R3 code 6 ignored, mode taken", 1'b0, 8'h0B);
      check_period("R3 ratio kept", 8);
      reg_write(1'b0, 8'h07);
      check_reg("R3 code 7 ignored", 1'b0, 8'h03);

      // R4 switch 2 -> 32 at period end
      reg_write(1'b0, 8'h01);
      wait_en();
      wait_en();
      addr = 1'b0; wr_data = 8'h05; wr_en = 1'b1;
      push_exp("R4 old period once", 2);
      g = 0;
      do begin @(negedge clk); wr_en = 1'b0; g++; end while (!bm_clk_en);
      observe(g);
      push_exp("R4 new period", 32);
      next_gap(g);
      observe(g);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule